// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block takes one byte at a time from a register write port and sends it as an asynchronous serial character. A written byte lands in a one-entry holding register. Whenever the shift engine is idle and the holding register is full, the engine takes the byte and frees the holding register for the next write. The engine then drives a low start bit, the data bits least significant first, an optional parity bit and the stop period, then returns to the high idle level. Each bit lasts `OVS` (16) pulses of an external oversampling tick. A 7-bit line-control input selects the character format. That format is captured when the byte enters the shifter, so changing it mid-character only affects later characters.

Line-control encoding: `[1:0]` sets the width, with 00/01/10/11 giving 5/6/7/8 data bits. `[2]` selects the long stop: 0 gives 16 ticks; 1 gives 24 ticks for 5-bit characters and 32 ticks for wider ones. `[5:3]` selects parity: `xx0` none, `001` odd, `011` even, `101` forced 1, `111` forced 0. `[6]` is the live break control, which holds the line low while the character underneath keeps shifting intact. Status outputs show an empty holding register and a fully idle transmitter. An interrupt follows the holding-register-empty status when it is enabled.

Engine states: `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_PARITY`, `ST_STOP`. Transitions:
- `ST_IDLE` to `ST_START` when the holding register is full; this is the load.
- `ST_START` to `ST_DATA` at the end of the bit.
- `ST_DATA` to `ST_DATA` after each bit until the last data bit.
- After the last data bit, `ST_DATA` goes to `ST_PARITY` when parity is on, or to `ST_STOP` when it is off.
- `ST_PARITY` to `ST_STOP` at the end of the bit.
- `ST_STOP` to `ST_IDLE` after the stop period.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `tx_empty` is 1 and `irq` equals `irq_en`.
- R2: A write sets the holding register full, so `hold_empty` reads 0 from the next cycle. While the engine is idle it loads the byte on the following clock, which starts the start bit and frees the holding register, and `tx_empty` stays 0 until the character ends.
- R3: A character is a 0 start bit, then data bits LSB first, with the width set by `line_ctl[1:0]` (00=5, 01=6, 10=7, 11=8). Each bit is held for 16 ticks, and data bits above the width are not sent.
- R4: With `line_ctl[3]`=1 a parity bit follows the last data bit. `[5:4]`=00 gives odd parity, 01 even, 10 a constant 1 and 11 a constant 0; parity covers only the sent data bits.
- R5: The stop period is high for 16 ticks when `line_ctl[2]`=0. When `line_ctl[2]`=1 it lasts 24 ticks for a 5-bit width and 32 ticks otherwise.
- R6: While `line_ctl[6]`=1, `txd` is 0. When break is released mid-character, the remaining bits appear exactly as they would have without the break.
- R7: `irq` is 1 exactly when `irq_en` is 1 and the holding register is empty, and a write clears it on the next cycle.
- R8: `tx_empty` rises on the tick that ends the stop period when nothing is pending. The format used is the one present at load, and changes to `line_ctl[5:0]` during a character have no effect on it.
- R9: With nothing to send, `txd` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| line_ctl | input | 7 | Width, stop, parity and break controls |
| irq_en | input | 1 | Enables the holding-empty interrupt |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register and shifter are both empty |
| irq | output | 1 | Holding-empty interrupt |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that software writes only while `hold_empty` is 1, so an unsent byte is never overwritten. They also assume that break is raised only after the start bit has begun. The stimulus keeps to these limits: the tick generator produces one pulse every four clocks, every write waits for the status that permits it, and break windows open only from the first data bit onward. Random formats, data and interrupt enables are mixed with directed cases for stick parity, the half-bit stop, back-to-back characters, break and a format change mid-character.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int BYTE_W  = 8;
    localparam int MIN_W   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic [1:0] wsel;      // width = MIN_W + wsel
        logic       stop_long;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } fmt_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R2: a write always leaves the register full
    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full);

endmodule

// File: rtl/sertx_fmt.sv
module sertx_fmt
    import sertx_pkg::*;
(
    input  logic [5:0]        lc,
    input  logic [BYTE_W-1:0] data,
    output fmt_t              fmt,
    output logic              par_bit
);

    logic [BYTE_W-1:0] keep;
    logic              fold;

    always_comb begin
        fmt.wsel      = lc[1:0];
        fmt.stop_long = lc[2];
        fmt.par_en    = lc[3];
        fmt.par_even  = lc[4];
        fmt.par_stick = lc[5];
    end

    // Mask the bits beyond the selected width before folding.
    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
            if (i < MIN_W) begin : g_always
                assign keep[i] = data[i];
            end else begin : g_sel
                assign keep[i] = data[i] & (int'(lc[1:0]) >= (i - MIN_W + 1));
            end
        end
    endgenerate

    assign fold = ^keep;

    always_comb begin
        if (fmt.par_stick)
            par_bit = ~fmt.par_even;
        else if (fmt.par_even)
            par_bit = fold;
        else
            par_bit = ~fold;
    end

endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [BYTE_W-1:0] hold_data,
    input  fmt_t              fmt_in,
    input  logic              par_in,
    output logic              take,
    output logic              ser_bit,
    output logic              busy
);

    localparam int CNT_W   = $clog2(2 * OVS);
    localparam int LIM_W   = CNT_W + 1;
    localparam int HALF    = OVS / 2;
    localparam int IDX_W   = $clog2(BYTE_W);

    tx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] sh_q;
    fmt_t              fmt_q;
    logic              par_q;
    logic [LIM_W-1:0]  stop_lim;
    logic [IDX_W-1:0]  last_idx;
    logic              bit_end, stop_end, phase_end;

    always_comb begin
        if (!fmt_q.stop_long)
            stop_lim = LIM_W'(OVS);
        else if (fmt_q.wsel == 2'd0)
            stop_lim = LIM_W'(OVS + HALF);
        else
            stop_lim = LIM_W'(2 * OVS);
    end

    assign last_idx  = IDX_W'(MIN_W - 1) + IDX_W'(fmt_q.wsel);
    assign bit_end   = tick && (cnt_q == CNT_W'(OVS - 1));
    assign stop_end  = tick && ({1'b0, cnt_q} == stop_lim - 1'b1);
    assign phase_end = (state_q == ST_STOP) ? stop_end : bit_end;
    assign take      = (state_q == ST_IDLE) && hold_full;
    assign busy      = (state_q != ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (hold_full) state_d = ST_START;
            ST_START:  if (bit_end)   state_d = ST_DATA;
            ST_DATA:   if (bit_end && idx_q == last_idx)
                           state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end)   state_d = ST_STOP;
            ST_STOP:   if (stop_end)  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath: counters, shifter and captured format
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            fmt_q <= '0;
            par_q <= 1'b0;
        end else if (take) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= hold_data;
            fmt_q <= fmt_in;
            par_q <= par_in;
        end else if (busy && tick) begin
            cnt_q <= phase_end ? '0 : cnt_q + 1'b1;
            if (state_q == ST_DATA && bit_end) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Output process
    always_comb begin
        unique case (state_q)
            ST_IDLE:   ser_bit = 1'b1;
            ST_START:  ser_bit = 1'b0;
            ST_DATA:   ser_bit = sh_q[0];
            ST_PARITY: ser_bit = par_q;
            ST_STOP:   ser_bit = 1'b1;
            default:   ser_bit = 1'b1;
        endcase
    end

    // R2: a load always begins with the start bit
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == ST_START));

    // R8: captured format does not move while a character is in flight
    a_r8_fmt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fmt_q));

    // R3: bit index never exceeds the selected width
    a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (idx_q <= last_idx));

    // R5: tick counter stays inside the current stop length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> ({1'b0, cnt_q} < stop_lim));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [6:0]        line_ctl,
    input  logic              irq_en,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty,
    output logic              irq
);

    logic              hold_full, take, ser_bit, busy, par_bit;
    logic [BYTE_W-1:0] hold_data;
    fmt_t              fmt;

    sertx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_fmt u_fmt (
        .lc      (line_ctl[5:0]),
        .data    (hold_data),
        .fmt     (fmt),
        .par_bit (par_bit)
    );

    sertx_engine #(.OVS(OVS)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .fmt_in    (fmt),
        .par_in    (par_bit),
        .take      (take),
        .ser_bit   (ser_bit),
        .busy      (busy)
    );

    // Break gates only the pin; the shifter underneath keeps running.
    assign txd        = ser_bit & ~line_ctl[6];
    assign hold_empty = ~hold_full;
    assign tx_empty   = ~hold_full & ~busy;
    assign irq        = irq_en & ~hold_full;

    // R6: break holds the line at space
    a_r6_break_space: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctl[6] |-> !txd);

    // R7: a write removes the interrupt on the next cycle
    a_r7_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq);

    // R2: a fully empty transmitter implies an empty holding register
    a_r2_empty_order: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] line_ctl = '0;
    logic       irq_en = 1'b0;
    logic       txd, hold_empty, tx_empty, irq;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_cnt = 0;
    bit done = 1'b0;

    sertx_top u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .line_ctl(line_ctl), .irq_en(irq_en),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty), .irq(irq)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    always @(posedge clk) if (baud_tick) tick_cnt = tick_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int width_of(input logic [5:0] lc);
        return 5 + int'(lc[1:0]);
    endfunction

    function automatic int stop_ticks(input logic [5:0] lc);
        if (!lc[2]) return 16;
        return (lc[1:0] == 2'b00) ? 24 : 32;
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [5:0] lc);
        logic x = 1'b0;
        for (int i = 0; i < width_of(lc); i++) x ^= d[i];
        if (lc[5]) return ~lc[4];
        return lc[4] ? x : ~x;
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input logic [5:0] lc, input int k);
        if (k == 0) return 1'b0;
        if (k <= width_of(lc)) return d[k-1];
        return exp_par(d, lc);
    endfunction

    task automatic wait_abs(input int t);
        wait (tick_cnt >= t);
        #1;
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(hold_empty == 1'b0, "R2 hold full after write", int'(hold_empty), 0);
        chk(irq == 1'b0, "R7 irq cleared by write", int'(irq), 0);
    endtask

    task automatic wait_fall();
        bit seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (!txd) seen = 1'b1;
        end
        chk(seen, "R2 start bit begins", int'(seen), 1);
        chk(hold_empty == 1'b1, "R2 holding freed on load", int'(hold_empty), 1);
        chk(tx_empty == 1'b0, "R2 tx busy", int'(tx_empty), 0);
    endtask

    task automatic check_frame(input logic [7:0] d, input logic [5:0] lc,
                               input bit pend, input logic [7:0] pend_d,
                               input int blo, input int bhi, input bit mutate);
        int w    = width_of(lc);
        int nb   = 1 + w + int'(lc[3]);
        int base = tick_cnt;
        int len  = stop_ticks(lc);
        for (int k = 0; k < nb; k++) begin
            bit br = (k >= blo) && (k <= bhi);
            logic e;
            line_ctl[6] = br;
            if (mutate && k == 1) line_ctl[5:0] = ~lc;
            wait_abs(base + k * 16 + 8);
            e = br ? 1'b0 : exp_bit(d, lc, k);
            if (br)
                chk(txd === e, "R6 break forces space", int'(txd), int'(e));
            else if (k > w)
                chk(txd === e, "R4 parity bit", int'(txd), int'(e));
            else if (mutate)
                chk(txd === e, "R8 format held from load", int'(txd), int'(e));
            else if (blo <= bhi && k > bhi)
                chk(txd === e, "R6 character intact after break", int'(txd), int'(e));
            else
                chk(txd === e, "R3 start/data bit", int'(txd), int'(e));
            if (pend && k == 1) begin
                put(pend_d);
                chk(tx_empty == 1'b0, "R2 tx_empty low with pending", int'(tx_empty), 0);
            end
        end
        line_ctl[6]   = 1'b0;
        line_ctl[5:0] = lc;
        wait_abs(base + nb * 16 + 8);
        chk(txd === 1'b1, "R5 stop level", int'(txd), 1);
        wait_abs(base + nb * 16 + len - 1);
        chk(txd === 1'b1, "R5 stop still high", int'(txd), 1);
        if (!pend) chk(tx_empty == 1'b0, "R5 stop not yet done", int'(tx_empty), 0);
        wait_abs(base + nb * 16 + len);
        if (!pend) chk(tx_empty == 1'b1, "R8 tx_empty at stop end", int'(tx_empty), 1);
    endtask

    task automatic send(input logic [7:0] d, input logic [5:0] lc);
        line_ctl = {1'b0, lc};
        put(d);
        wait_fall();
        check_frame(d, lc, 1'b0, 8'h00, 99, -1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        irq_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        chk(hold_empty == 1'b1, "R1 reset hold_empty", int'(hold_empty), 1);
        chk(tx_empty == 1'b1, "R1 reset tx_empty", int'(tx_empty), 1);
        chk(irq == 1'b1, "R1 reset irq", int'(irq), 1);

        send(8'hA5, 6'b000_0_11);   // 8 bits, no parity, 1 stop
        send(8'hFF, 6'b000_1_00);   // 5 bits, 1.5 stop
        send(8'h2A, 6'b000_1_01);   // 6 bits, 2 stop
        send(8'h3C, 6'b001_0_10);   // 7 bits, odd
        send(8'h81, 6'b011_0_11);   // 8 bits, even
        send(8'h00, 6'b101_0_00);   // stick 1
        send(8'hFF, 6'b111_0_11);   // stick 0
        chk(irq == 1'b1, "R7 irq when empty and enabled", int'(irq), 1);

        // break over bits 2..5, character must resume intact
        line_ctl = 7'b000_0011;
        put(8'h96);
        wait_fall();
        check_frame(8'h96, 6'b000011, 1'b0, 8'h00, 2, 5, 1'b0);

        // back-to-back characters
        line_ctl = 7'b001_1011;
        put(8'h5A);
        wait_fall();
        check_frame(8'h5A, 6'b011011, 1'b1, 8'hC3, 99, -1, 1'b0);
        wait_fall();
        check_frame(8'hC3, 6'b011011, 1'b0, 8'h00, 99, -1, 1'b0);

        // format changed mid-character
        line_ctl = 7'b000_1110;
        put(8'h6D);
        wait_fall();
        check_frame(8'h6D, 6'b001110, 1'b0, 8'h00, 99, -1, 1'b1);

        // idle line
        repeat (40) @(negedge clk);
        chk(txd == 1'b1, "R9 idle high", int'(txd), 1);

        for (int n = 0; n < 30; n++) begin
            logic [7:0] d  = 8'($urandom);
            logic [5:0] lc = 6'($urandom);
            irq_en = 1'($urandom);
            send(d, lc);
            @(negedge clk);
            chk(irq == irq_en, "R7 irq follows enable", int'(irq), int'(irq_en));
            chk(txd == 1'b1, "R9 line high after character", int'(txd), 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule